// File: doc/BRIEF.md
# Read-Triggered ADC Conversion Controller

This block runs the conversion engine of an analog-to-digital converter for a CPU that sees it as two word registers. A read of the result register has a side effect: it is the only way to start a conversion. The same read returns the status flag in bit 31 and the formatted 16-bit sample in bits 15:0. Software repeats the read until bit 31 comes back as 1. The read that returns the 1 also clears it.

The engine is clocked by a tick enable. A prescaler divides the reference clock by 4 or by 16 to make this tick. A conversion lasts `CONV_TICKS` ticks. At the last tick the converter's sample input is captured and a rest counter of `GAP_TICKS` ticks is loaded. A read that collects a finished result starts the next conversion only when the rest time has already passed. Otherwise the controller waits in a rest state and then returns to idle. Reads made during a conversion or during the rest time report status only and start nothing. A configuration register holds the divider select and the unsigned or signed output format.

States: IDLE (no result pending), CONV (converting), DONE (result ready, flag set), REST (result collected, rest time running). Transitions: IDLE→CONV on a result read. CONV→DONE on the final tick. DONE→CONV on a result read when the rest time has passed. DONE→REST on a result read while rest time remains. REST→IDLE when the rest counter reaches zero.

Top module: `adc_read_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the controller in IDLE. A result read then returns 0, with bit 31 at 0 and the sample at 0. The configuration register reads 0, which selects divide-by-4 and unsigned format.
- R2: Only a read (`rd_en`=1) at address 0 starts a conversion. Idle cycles, configuration reads and writes to address 0 leave the controller idle.
- R3: A conversion ends on the `CONV_TICKS`-th prescaler tick counted after its start. The `smp_in` value present at that clock edge becomes the stored sample.
- R4: Bit 31 of a result read is 1 only in DONE. A result read that returns 1 makes the next result reads return 0 until another conversion completes.
- R5: Result reads during CONV neither restart nor lengthen the conversion, and they do not change the sample it captures.
- R6: A result read in DONE starts a new conversion only if `GAP_TICKS` ticks have passed since completion. Otherwise the controller enters REST, where reads start nothing, and it returns to IDLE when the rest time runs out.
- R7: Configuration bit 16 selects the tick rate: 0 gives one tick every 4 clocks, 1 gives one every 16. The prescaler runs freely from reset, and a tick falls on each clock whose count since reset is 3 mod 4 or 15 mod 16.
- R8: Configuration bit 0 selects the format. When it is 0, bits 15:0 show the raw sample. When it is 1, they show the sample with bit 15 inverted (offset binary to two's complement, so mid-scale 0x8000 reads 0x0000). Bits 30:16 are always 0.
- R9: The stored sample stays stable until the next conversion completes, whatever `smp_in` does in between.
- R10: Address 1 reads back bit 16 and bit 0 as written, with all other bits 0. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; side effect only at address 0 |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 result, 1 configuration |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| smp_in | input | 16 | Converter sample from the analog side |

## Verification
The bench builds the controller with `CONV_TICKS`=3 and `GAP_TICKS`=2. This keeps a conversion to about a dozen clocks at divide-by-4, so continuous polling passes through every state and both outcomes of a DONE read within a short run. At these values the rest time is short enough to expire during a long idle stretch and long enough to still be running when software reads back to back. The slow divider run then shows the same sequence stretched fourfold.

// File: rtl/adc_rc_pkg.sv
package adc_rc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2,
        ST_REST = 2'd3
    } seq_state_t;

    localparam int          ADDR_W   = 2;
    localparam int          SAMPLE_W = 16;
    localparam logic [1:0]  A_RESULT = 2'd0;
    localparam logic [1:0]  A_CONFIG = 2'd1;
    localparam int          SLOW_BIT = 16;
    localparam int          SIGN_BIT = 0;
    localparam int          FLAG_BIT = 31;
endpackage

// File: rtl/adc_rc_prescale.sv
module adc_rc_prescale #(
    parameter int FAST_LOG2 = 2,
    parameter int SLOW_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    output logic tick
);
    logic [SLOW_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign tick = slow ? (&cnt) : (&cnt[FAST_LOG2-1:0]);

    // R7: ticks never come on two adjacent clocks
    assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/adc_rc_seq.sv
module adc_rc_seq
    import adc_rc_pkg::*;
#(
    parameter int CONV_TICKS = 16,
    parameter int GAP_TICKS  = 64,
    parameter int SMP_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rd_res,
    input  logic [SMP_W-1:0] smp,
    output logic             done,
    output logic [SMP_W-1:0] res
);
    localparam int CC_W = $clog2(CONV_TICKS + 1);
    localparam int GC_W = $clog2(GAP_TICKS + 1);

    seq_state_t      state, nxt;
    logic [CC_W-1:0] cc;
    logic [GC_W-1:0] gcnt;
    logic            last, gap_zero, go;

    assign last     = (cc == CC_W'(CONV_TICKS - 1));
    assign gap_zero = (gcnt == '0);
    assign go       = rd_res && ((state == ST_IDLE) || (state == ST_DONE && gap_zero));

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (rd_res)       nxt = ST_CONV;
            ST_CONV: if (tick && last) nxt = ST_DONE;
            ST_DONE: if (rd_res)       nxt = gap_zero ? ST_CONV : ST_REST;
            ST_REST: if (gap_zero)     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cc   <= '0;
            gcnt <= '0;
            res  <= '0;
        end else begin
            if (go)
                cc <= '0;
            else if (state == ST_CONV && tick && !last)
                cc <= cc + 1'b1;

            if (state == ST_CONV && tick && last) begin
                res  <= smp;
                gcnt <= GC_W'(GAP_TICKS);
            end else if ((state == ST_DONE || state == ST_REST) && tick && !gap_zero) begin
                gcnt <= gcnt - 1'b1;
            end
        end
    end

    assign done = (state == ST_DONE);

    // R2: idle holds without a result read
    assert_idle_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rd_res) |=> state == ST_IDLE);
    // R5: between ticks a running conversion keeps its progress
    assert_conv_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && !tick) |=> (state == ST_CONV && $stable(cc)));
    // R6: the rest state never launches a conversion
    assert_rest_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST) |=> state != ST_CONV);
    // R9: stored sample changes only when a conversion completes
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CONV) |=> $stable(res));
endmodule

// File: rtl/adc_rc_fmt.sv
module adc_rc_fmt
    import adc_rc_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                done,
    input  logic [SAMPLE_W-1:0] res,
    input  logic                slow,
    input  logic                sgn,
    output logic [31:0]         rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_RESULT: begin
                rdata[FLAG_BIT]       = done;
                rdata[SAMPLE_W-1:0]   = res ^ {sgn, {(SAMPLE_W-1){1'b0}}};
            end
            A_CONFIG: begin
                rdata[SLOW_BIT] = slow;
                rdata[SIGN_BIT] = sgn;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rc_pkg::*;
#(
    parameter int CONV_TICKS = 16,
    parameter int GAP_TICKS  = 64,
    parameter int FAST_LOG2  = 2,
    parameter int SLOW_LOG2  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [15:0] smp_in
);
    logic                slow_q, sgn_q;
    logic                tick, rd_res, done_w;
    logic [SAMPLE_W-1:0] res_w;
    logic                unused_wdata_bits;

    assign unused_wdata_bits = ^{wdata[31:SLOW_BIT+1], wdata[SLOW_BIT-1:SIGN_BIT+1]};
    assign rd_res = rd_en && (addr == A_RESULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q <= 1'b0;
            sgn_q  <= 1'b0;
        end else if (wr_en && addr == A_CONFIG) begin
            slow_q <= wdata[SLOW_BIT];
            sgn_q  <= wdata[SIGN_BIT];
        end
    end

    adc_rc_prescale #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
        .clk(clk), .rst(rst), .slow(slow_q), .tick(tick)
    );

    adc_rc_seq #(.CONV_TICKS(CONV_TICKS), .GAP_TICKS(GAP_TICKS), .SMP_W(SAMPLE_W)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .rd_res(rd_res), .smp(smp_in),
        .done(done_w), .res(res_w)
    );

    adc_rc_fmt u_fmt (
        .addr(addr), .done(done_w), .res(res_w), .slow(slow_q), .sgn(sgn_q), .rdata(rdata)
    );

    // R4: collecting a finished result clears the flag on the next cycle
    assert_flag_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_res && done_w) |=> !done_w);
    // R8: the bits between sample and flag are always zero
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (addr == A_RESULT) |-> (rdata[30:16] == 15'd0));
endmodule

// File: tb/adc_read_ctrl_tb_top.sv
module adc_read_ctrl_tb_top;
    localparam int CT = 3;
    localparam int GT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [15:0] smp_in = '0;
    logic [31:0] rdata;

    int vectors = 0;
    int miss = 0;

    // behavioural model: 0 idle, 1 converting, 2 ready, 3 resting
    int          m_st = 0, m_cc = 0, m_gap = 0, m_cyc = 0;
    logic [15:0] m_res = '0;
    bit          m_slow = 0, m_sgn = 0;

    always #2 clk = ~clk;

    adc_read_ctrl #(.CONV_TICKS(CT), .GAP_TICKS(GT)) dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .smp_in(smp_in)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cc = 0; m_gap = 0; m_cyc = 0; m_res = '0; m_slow = 0; m_sgn = 0;
        end else begin
            int  dv;
            bit  tk, rr;
            int  ost, ogap;
            dv   = m_slow ? 16 : 4;
            tk   = ((m_cyc % dv) == dv - 1);
            rr   = rd_en && (addr == 2'd0);
            ost  = m_st;
            ogap = m_gap;
            case (ost)
                0: if (rr) begin m_st = 1; m_cc = 0; end
                1: if (tk) begin
                       if (m_cc == CT - 1) begin m_st = 2; m_res = smp_in; m_gap = GT; end
                       else m_cc++;
                   end
                2: begin
                       if (tk && ogap > 0) m_gap = ogap - 1;
                       if (rr) begin
                           if (ogap == 0) begin m_st = 1; m_cc = 0; end
                           else m_st = 3;
                       end
                   end
                default: begin
                       if (tk && ogap > 0) m_gap = ogap - 1;
                       if (ogap == 0) m_st = 0;
                   end
            endcase
            if (wr_en && addr == 2'd1) begin m_slow = wdata[16]; m_sgn = wdata[0]; end
            m_cyc = (m_cyc + 1) % 16;
        end
    end

    function automatic logic [31:0] model_rdata();
        logic [31:0] v = '0;
        if (addr == 2'd0) begin
            v[31]   = (m_st == 2);
            v[15:0] = m_sgn ? (m_res ^ 16'h8000) : m_res;
        end else if (addr == 2'd1) begin
            v[16] = m_slow;
            v[0]  = m_sgn;
        end
        return v;
    endfunction

    task automatic step(input bit r, input bit w, input logic [1:0] a,
                        input logic [31:0] d, input logic [15:0] s, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wdata = d; smp_in = s;
        #1;
        exp = model_rdata();
        vectors++;
        if (rdata !== exp) begin
            miss++;
            $display("FAIL %s rdata=%h expected=%h", tag, rdata, exp);
        end
    endtask

    task automatic convert(input logic [15:0] s, input int n, input string tag);
        step(1, 0, 2'd0, '0, s, tag);
        for (int i = 0; i < n; i++) step(0, 0, 2'd0, '0, s, tag);
        for (int i = 0; i < 8; i++) step(0, 0, 2'd0, '0, s ^ 16'hA5A5, "R9");
        step(1, 0, 2'd0, '0, s ^ 16'hA5A5, "R4");
        step(0, 0, 2'd0, '0, s ^ 16'hA5A5, "R4");
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog (all requirements) rdata=%h expected=run end", rdata);
        summary();
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: state during and after reset
        step(0, 0, 2'd0, '0, 16'h1234, "R1");
        step(0, 0, 2'd1, '0, 16'h1234, "R1");
        rst = 1'b0;
        step(0, 0, 2'd0, '0, 16'h1234, "R1");
        step(0, 0, 2'd1, '0, 16'h1234, "R1");
        // R2: writes to the result address and config reads start nothing
        step(0, 1, 2'd0, 32'hFFFF_FFFF, 16'h4321, "R2");
        for (int i = 0; i < 20; i++) step(0, 0, 2'd1, '0, 16'h4321, "R2");
        step(0, 0, 2'd2, '0, 16'h4321, "R10");
        step(0, 0, 2'd3, '0, 16'h4321, "R10");
        // R3/R5: start, then poll on every clock with a moving sample
        step(1, 0, 2'd0, '0, 16'h0100, "R3");
        for (int i = 0; i < 24; i++) step(1, 0, 2'd0, '0, 16'(16'h0111 * i), "R5");
        // R6: back-to-back polling through rest and idle
        for (int i = 0; i < 30; i++) step(1, 0, 2'd0, '0, 16'(16'h0F00 + i), "R6");
        // R6: let rest expire, then a single collecting read restarts at once
        for (int i = 0; i < 50; i++) step(0, 0, 2'd0, '0, 16'h2468, "R6");
        step(1, 0, 2'd0, '0, 16'h2468, "R6");
        for (int i = 0; i < 20; i++) step(0, 0, 2'd0, '0, 16'h1357, "R3");
        // R10: configuration read-back
        step(0, 1, 2'd1, 32'hFFFF_FFFF, 16'h1357, "R10");
        step(0, 0, 2'd1, '0, 16'h1357, "R10");
        step(0, 1, 2'd1, 32'h0000_0000, 16'h1357, "R10");
        step(0, 0, 2'd1, '0, 16'h1357, "R10");
        // R8: unsigned then signed formatting at both ends and near full span
        convert(16'hFFFF, 60, "R8");
        step(0, 1, 2'd1, 32'h0000_0001, 16'h0, "R8");
        convert(16'h0000, 60, "R8");
        convert(16'h8000, 60, "R8");
        convert(16'hE1A8, 60, "R8");
        convert(16'h1E58, 60, "R8");
        // R7: slow divider
        step(0, 1, 2'd1, 32'h0001_0000, 16'h0, "R7");
        convert(16'h7777, 120, "R7");
        for (int i = 0; i < 100; i++) step(1, 0, 2'd0, '0, 16'(16'h3000 + i), "R7");
        step(0, 1, 2'd1, 32'h0000_0000, 16'h0, "R7");
        convert(16'h0ACE, 60, "R7");
        // R1: reset mid-conversion
        step(1, 0, 2'd0, '0, 16'h5555, "R1");
        rst = 1'b1;
        step(0, 0, 2'd0, '0, 16'h5555, "R1");
        step(0, 0, 2'd1, '0, 16'h5555, "R1");
        rst = 1'b0;
        for (int i = 0; i < 10; i++) step(0, 0, 2'd0, '0, 16'h5555, "R1");
        summary();
    end
endmodule